// File: doc/BRIEF.md
# Buffered Nonvolatile Write Commit Controller

This block sits behind an SPI slave front end and decides, at the moment chip select is released, whether a buffered nonvolatile write may be committed to the storage array. During a frame, the front end hands it the decoded instruction, the start address, a running count of data bits received after the address, and a strobe for each completed data byte that says whether the storage model accepts that byte. The block follows the byte pointer itself, so it can apply the address-region rules: user memory honours a protection input, the configuration segment never accepts its lowest ten offsets, and every other region accepts nothing.

A write-enable latch gates every commit. A separate enable instruction sets the latch, and that instruction only takes effect once its own frame has ended. When all commit conditions hold, the block starts a programming timer. It raises a busy flag for exactly the programming time and clears the latch when the timer expires. When any condition fails, no programming cycle starts and the latch keeps its value. Chip select is synchronized into the system clock domain, and its rising edge is detected there.

Top module: `nv_commit_ctrl`

## Requirements
- R1: An enable instruction (opEnable high during the frame) sets writeEnLatch only after chip select is released. While that frame is still open, the latch keeps its old value.
- R2: When chip select is released with opWrite high, writeEnLatch set, a data bit count that is nonzero and a multiple of 8, and at least one writable byte, busy goes high on the third rising clock edge after csN rises.
- R3: Once started, busy stays high for exactly PROG_CYCLES clock cycles. commitPulse is high for exactly one cycle, in the first cycle of busy.
- R4: writeEnLatch is cleared in the same cycle that busy falls. It stays set for the whole time busy is high.
- R5: If dataBits is not a multiple of 8, no commit starts and writeEnLatch keeps its value.
- R6: In user memory (address segment index below USER_SEGS, segment = startAddr[ADDR_W-1:SEG_W]), bytes do not count as writable while wrProt is high. In that case no commit starts and the latch is kept.
- R7: In the configuration segment (segment index CFG_SEG), bytes at offsets below CFG_SKIP (10) never count as writable. A write that only touches those offsets does not commit.
- R8: A write whose start address lies in any other segment (neither user nor configuration) never commits and leaves the latch set.
- R9: The byte pointer starts at startAddr[SEG_W-1:0], advances by one for each completed byte, and wraps from the last offset of a segment to offset 0 of the same segment.
- R10: A byte strobed with byteWritable low does not count. If no byte counts as writable, no commit starts and the latch is kept.
- R11: While busy is high, both write and enable instructions are ignored. No second commit follows, and the latch is not set again.
- R12: After reset, busy, writeEnLatch and commitPulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | SPI chip select, active low, asynchronous to clk |
| opWrite | input | 1 | Decoded write instruction for the current frame, held until after release |
| opEnable | input | 1 | Decoded write-enable instruction for the current frame |
| addrValid | input | 1 | One-cycle strobe: startAddr is valid |
| startAddr | input | ADDR_W | Start address of the write |
| dataBits | input | CNT_W | Number of data bits received after the address |
| byteDone | input | 1 | One-cycle strobe per completed data byte |
| byteWritable | input | 1 | Storage model accepts the byte strobed by byteDone |
| wrProt | input | 1 | Write protection for user memory |
| busy | output | 1 | Programming cycle in progress |
| writeEnLatch | output | 1 | Write-enable latch |
| commitPulse | output | 1 | One-cycle strobe when a commit starts |

## Verification
Any wrong internal state reaches the ports within a few cycles. A byte pointer or segment decode that is off shows up as a wrong busy value three clock edges after chip select is released. A timer that is loaded or counted wrongly changes the length of busy, and a cycle-by-cycle count of busy catches that. A latch that clears or sets in the wrong case shows up in the writeEnLatch value seen after the frame, or after busy falls. The effect of that error then carries into the next frame's commit decision.

// File: rtl/nv_commit_pkg.sv
package nv_commit_pkg;

  typedef enum logic [1:0] {
    SEG_USER = 2'd0,
    SEG_CFG  = 2'd1,
    SEG_NONE = 2'd2
  } segKind_t;

  typedef struct packed {
    logic loadTimer;
    logic clrFrame;
  } ctlStrobes_t;

endpackage

// File: rtl/nv_commit_datapath.sv
module nv_commit_datapath
  import nv_commit_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SEG_W       = 4,
  parameter int CNT_W       = 12,
  parameter int USER_SEGS   = 8,
  parameter int CFG_SEG     = 8,
  parameter int CFG_SKIP    = 10,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  dataBits,
  input  logic              byteDone,
  input  logic              byteWritable,
  input  logic              wrProt,
  output logic              wholeBytes,
  output logic              anyWritable,
  output logic              timerDone
);
  localparam int SEG_IDX_W = ADDR_W - SEG_W;
  localparam int TMR_W     = $clog2(PROG_CYCLES + 1);

  logic [SEG_IDX_W-1:0] segIdx;
  logic [SEG_W-1:0]     ptr;
  logic [TMR_W-1:0]     timer;
  segKind_t             segKind;
  logic                 byteOk;

  always_comb begin
    if (int'(segIdx) < USER_SEGS)       segKind = SEG_USER;
    else if (int'(segIdx) == CFG_SEG)   segKind = SEG_CFG;
    else                                segKind = SEG_NONE;
  end

  always_comb begin
    unique case (segKind)
      SEG_USER: byteOk = byteWritable && !wrProt;
      SEG_CFG:  byteOk = byteWritable && (ptr >= SEG_W'(CFG_SKIP));
      default:  byteOk = 1'b0;
    endcase
  end

  // frame tracking: pointer and writable-byte flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segIdx      <= '1;
      ptr         <= '0;
      anyWritable <= 1'b0;
    end else if (addrValid) begin
      segIdx      <= startAddr[ADDR_W-1:SEG_W];
      ptr         <= startAddr[SEG_W-1:0];
      anyWritable <= 1'b0;
    end else if (strobes.clrFrame) begin
      anyWritable <= 1'b0;
    end else if (byteDone) begin
      if (byteOk) anyWritable <= 1'b1;
      ptr <= ptr + 1'b1;
    end
  end

  assign wholeBytes = (dataBits != '0) && (dataBits[2:0] == 3'd0);

  // programming timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  timer <= '0;
    else if (strobes.loadTimer) timer <= TMR_W'(PROG_CYCLES - 1);
    else if (timer != '0)       timer <= timer - 1'b1;
  end

  assign timerDone = (timer == '0);

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TMR_W'(PROG_CYCLES - 1)); // R3

  AST_CFG_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && !addrValid && !strobes.clrFrame && segKind == SEG_CFG &&
     ptr < SEG_W'(CFG_SKIP) && !anyWritable) |=> !anyWritable); // R7

  AST_NONE_SEG: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && !addrValid && segKind == SEG_NONE && !anyWritable) |=> !anyWritable); // R8

endmodule

// File: rtl/nv_commit_control.sv
module nv_commit_control
  import nv_commit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        opWrite,
  input  logic        opEnable,
  input  logic        wholeBytes,
  input  logic        anyWritable,
  input  logic        timerDone,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        writeEnLatch,
  output logic        commitPulse
);
  logic csMeta, csSync, csPrev;
  logic csRise, goCommit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csMeta <= 1'b1;
      csSync <= 1'b1;
      csPrev <= 1'b1;
    end else begin
      csMeta <= csN;
      csSync <= csMeta;
      csPrev <= csSync;
    end
  end

  assign csRise   = csSync && !csPrev;
  assign goCommit = csRise && !busy && !opEnable && opWrite &&
                    writeEnLatch && wholeBytes && anyWritable;

  always_comb begin
    strobes.loadTimer = goCommit;
    strobes.clrFrame  = csRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      writeEnLatch <= 1'b0;
      commitPulse  <= 1'b0;
    end else begin
      commitPulse <= 1'b0;
      if (busy && timerDone) begin
        busy         <= 1'b0;
        writeEnLatch <= 1'b0;
      end else if (csRise && !busy) begin
        if (opEnable) begin
          writeEnLatch <= 1'b1;
        end else if (goCommit) begin
          busy        <= 1'b1;
          commitPulse <= 1'b1;
        end
      end
    end
  end

  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> writeEnLatch); // R4

  AST_WEL_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !writeEnLatch); // R4

  AST_START_CONDITIONS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wholeBytes && anyWritable && writeEnLatch && opWrite)); // R2

  AST_PULSE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $rose(busy)); // R3

  AST_WEL_SET_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeEnLatch) |-> $past(csRise)); // R1

endmodule

// File: rtl/nv_commit_ctrl.sv
module nv_commit_ctrl
  import nv_commit_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SEG_W       = 4,
  parameter int CNT_W       = 12,
  parameter int USER_SEGS   = 8,
  parameter int CFG_SEG     = 8,
  parameter int CFG_SKIP    = 10,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              opWrite,
  input  logic              opEnable,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  dataBits,
  input  logic              byteDone,
  input  logic              byteWritable,
  input  logic              wrProt,
  output logic              busy,
  output logic              writeEnLatch,
  output logic              commitPulse
);
  ctlStrobes_t strobes;
  logic wholeBytes, anyWritable, timerDone;

  nv_commit_control control_i (
    .clk          (clk),
    .rstN         (rstN),
    .csN          (csN),
    .opWrite      (opWrite),
    .opEnable     (opEnable),
    .wholeBytes   (wholeBytes),
    .anyWritable  (anyWritable),
    .timerDone    (timerDone),
    .strobes      (strobes),
    .busy         (busy),
    .writeEnLatch (writeEnLatch),
    .commitPulse  (commitPulse)
  );

  nv_commit_datapath #(
    .ADDR_W      (ADDR_W),
    .SEG_W       (SEG_W),
    .CNT_W       (CNT_W),
    .USER_SEGS   (USER_SEGS),
    .CFG_SEG     (CFG_SEG),
    .CFG_SKIP    (CFG_SKIP),
    .PROG_CYCLES (PROG_CYCLES)
  ) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .addrValid    (addrValid),
    .startAddr    (startAddr),
    .dataBits     (dataBits),
    .byteDone     (byteDone),
    .byteWritable (byteWritable),
    .wrProt       (wrProt),
    .wholeBytes   (wholeBytes),
    .anyWritable  (anyWritable),
    .timerDone    (timerDone)
  );

endmodule

// File: tb/nv_commit_ctrl_tb.sv
module nv_commit_ctrl_tb_top;
  localparam int PROG = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        opWrite = 1'b0, opEnable = 1'b0;
  logic        addrValid = 1'b0;
  logic [8:0]  startAddr = '0;
  logic [11:0] dataBits = '0;
  logic        byteDone = 1'b0, byteWritable = 1'b0, wrProt = 1'b0;
  logic        busy, writeEnLatch, commitPulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic welModel = 1'b0;

  always #2.5 clk = ~clk;

  nv_commit_ctrl #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .opWrite(opWrite), .opEnable(opEnable),
    .addrValid(addrValid), .startAddr(startAddr), .dataBits(dataBits),
    .byteDone(byteDone), .byteWritable(byteWritable), .wrProt(wrProt),
    .busy(busy), .writeEnLatch(writeEnLatch), .commitPulse(commitPulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // opens a frame, sends the address and bytes, releases chip select
  task automatic frameOpen(input logic isWr, input logic isEn, input logic [8:0] addr,
                           input int nBytes, input int extra, input logic [15:0] mask);
    @(negedge clk);
    csN = 1'b0; opWrite = isWr; opEnable = isEn; dataBits = '0;
    repeat (2) @(negedge clk);
    if (isWr) begin
      startAddr = addr; addrValid = 1'b1;
      @(negedge clk); addrValid = 1'b0;
      for (int i = 0; i < nBytes; i++) begin
        dataBits = dataBits + 12'd8; byteWritable = mask[i]; byteDone = 1'b1;
        @(negedge clk); byteDone = 1'b0; byteWritable = 1'b0;
      end
      dataBits = dataBits + 12'(extra);
    end
    @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic frameClose();
    repeat (5) @(negedge clk);
    opWrite = 1'b0; opEnable = 1'b0; dataBits = '0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // {tag[3:0], en, addr[8:0], nBytes[3:0], extra[2:0], mask[15:0], prot, exp}
  localparam int NV = 12;
  localparam logic [38:0] VEC [NV] = '{
    {4'd2,  1'b1, 9'h010, 4'd2, 3'd0, 16'h0003, 1'b0, 1'b1}, // R2 all conditions met
    {4'd2,  1'b0, 9'h010, 4'd2, 3'd0, 16'h0003, 1'b0, 1'b0}, // R2 latch clear
    {4'd5,  1'b1, 9'h010, 4'd2, 3'd3, 16'h0003, 1'b0, 1'b0}, // R5 partial byte
    {4'd6,  1'b0, 9'h010, 4'd2, 3'd0, 16'h0003, 1'b1, 1'b0}, // R6 protected
    {4'd7,  1'b0, 9'h080, 4'd3, 3'd0, 16'h0007, 1'b0, 1'b0}, // R7 only skipped offsets
    {4'd7,  1'b0, 9'h088, 4'd3, 3'd0, 16'h0007, 1'b0, 1'b1}, // R7 reaches offset 10
    {4'd8,  1'b1, 9'h0A0, 4'd2, 3'd0, 16'h0003, 1'b0, 1'b0}, // R8 no such segment
    {4'd9,  1'b0, 9'h08F, 4'd2, 3'd0, 16'h0003, 1'b0, 1'b1}, // R9 offset 15 writable
    {4'd9,  1'b1, 9'h08E, 4'd4, 3'd0, 16'h000C, 1'b0, 1'b0}, // R9 wrap to offsets 0,1
    {4'd10, 1'b0, 9'h020, 4'd0, 3'd0, 16'h0000, 1'b0, 1'b0}, // R10 no bytes
    {4'd10, 1'b0, 9'h030, 4'd1, 3'd0, 16'h0000, 1'b0, 1'b0}, // R10 byte refused
    {4'd2,  1'b0, 9'h030, 4'd1, 3'd0, 16'h0001, 1'b0, 1'b1}  // R2 user byte accepted
  };

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 busy", busy, 1'b0);
    check("R12 latch", writeEnLatch, 1'b0);
    check("R12 pulse", commitPulse, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [38:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d row %0d", e[38:35], v);
      if (e[34]) begin
        frameOpen(1'b0, 1'b1, '0, 0, 0, '0); frameClose();
        welModel = 1'b1;
      end
      wrProt = e[1];
      frameOpen(1'b1, 1'b0, e[33:25], int'(e[24:21]), int'(e[20:18]), e[17:2]);
      frameClose();
      check(tag, busy, e[0]);
      waitIdle();
      wrProt = 1'b0;
      if (e[0]) welModel = 1'b0;
      check(e[0] ? "R4 latch after commit" : tag, writeEnLatch, welModel);
    end

    // R1: latch not set until the enable frame ends
    @(negedge clk); csN = 1'b0; opEnable = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 latch while frame open", writeEnLatch, 1'b0);
    csN = 1'b1;
    frameClose();
    check("R1 latch after release", writeEnLatch, 1'b1);

    // R2/R3: commit timing, busy length, single pulse
    begin
      int busyCnt, pulseCnt, riseAt;
      busyCnt = 0; pulseCnt = 0; riseAt = -1;
      frameOpen(1'b1, 1'b0, 9'h040, 1, 0, 16'h0001);
      for (int c = 0; c < PROG + 20; c++) begin
        @(negedge clk);
        if (c == 5) begin opWrite = 1'b0; dataBits = '0; end
        if (busy) busyCnt++;
        if (commitPulse) begin
          pulseCnt++;
          if (busyCnt != 1) check("R3 pulse in first busy cycle", 1'b0, 1'b1);
        end
        if (busy && riseAt < 0) riseAt = c;
      end
      // csN rose at negedge; edges 1,2 sync, edge 3 commits -> seen at 3rd negedge (c=2)
      check("R2 busy rises on third edge", riseAt == 2, 1'b1);
      check("R3 busy length", busyCnt == PROG, 1'b1);
      check("R3 single pulse", pulseCnt == 1, 1'b1);
      check("R4 latch cleared at end", writeEnLatch, 1'b0);
    end

    // R11: instructions ignored while busy
    frameOpen(1'b0, 1'b1, '0, 0, 0, '0); frameClose();
    frameOpen(1'b1, 1'b0, 9'h040, 1, 0, 16'h0001); frameClose();
    check("R11 commit started", busy, 1'b1);
    frameOpen(1'b0, 1'b1, '0, 0, 0, '0); frameClose();
    frameOpen(1'b1, 1'b0, 9'h041, 1, 0, 16'h0001); frameClose();
    waitIdle();
    repeat (10) @(negedge clk);
    check("R11 no second commit", busy, 1'b0);
    check("R11 latch not set again", writeEnLatch, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule